// File: doc/BRIEF.md
# Snooping Three-Owner-State Cache-Line Coherence Controller

This block keeps one cache line coherent in a broadcast snooping system that has an ordered address network and a separate, unordered data network. It takes processor requests, snooped address-network requests tagged with a requestor ID, and data arrivals. From these it produces request strobes (shared read, fetch read, exclusive read, writeback), data-send commands naming a destination set, fill commands toward the data array, load and store completion strobes, and the line's access permission. The line can be Modified, Owned, Shared, Invalid or not present. Transient states record two things: whether this controller's own request has been seen in the global order, and whether its data has arrived.

A small transaction record holds buffered data, a prefetch flag and a bitmask of requestors waiting for data. While it waits for its data after its own exclusive request is ordered, the controller adds every later snooped reader or writer to that mask. When the data arrives it forwards the data to the whole mask. The data array and the interconnect sit outside the block. The array's current line contents arrive on `arr_data`.

The controller handles one event per cycle, chosen by a fixed precedence. A snooped request is always taken. Data input is a valid/ready stream whose ready falls only while a snoop is present. The processor port is a valid/ready stream. Its ready is low while a snoop or data is present, and also in any state that must hold the request. A held request waits at the head with no state change.

Top module: `mosi_line_ctrl`

## Requirements
- R1: During and right after reset the line is not present: `perm` is 0 (no access), `proc_ready` is 1 with no other input active, and no strobe, send or fill is active.
- R2: A snoop whose `snp_id` equals `MY_ID` is this controller's own request; any other ID is another controller's. Snoop type codes are 0 shared read, 1 fetch read, 2 exclusive read, 3 writeback. A writeback from another controller has no effect in any state.
- R3: From not-present or Invalid, processor op codes 0 load, 1 fetch and 3 load-prefetch raise one request strobe and enter a busy wait: `iss_ird` for a fetch, `iss_rd` otherwise. Op codes 2 store and 4 store-prefetch raise `iss_rdx`. At most one request strobe is high in any cycle.
- R4: With access, a load or fetch completes in the same cycle with `done_ld` in Shared, Owned or Modified. A store completes with `done_st` in Modified. A prefetch that already has sufficient access has no effect.
- R5: `done_ld` and `done_st` stay low whenever the transaction record is active with its prefetch flag set, so a miss started by a prefetch completes silently.
- R6: In Modified, another controller's shared or fetch read sends the array data to that requestor alone (`send_dest` one-hot at its ID) and moves to Owned. Another controller's exclusive read moves Shared, Owned or Modified to Invalid and sends data only from Owned or Modified.
- R7: If data arrives before the own request is ordered, the data is buffered. The own ordered request then fills the array from the buffer and completes: a read ends in Shared, an exclusive read in Modified.
- R8: After its own exclusive read is ordered and before data arrives, each other read or exclusive read sets that requestor's bit in the forward mask; nothing after the first other exclusive read is recorded. On data arrival the line is filled from the incoming data, `done_st` fires, and the data is sent to the mask. The line ends Modified with no other requests, Owned with readers only, and Invalid if an exclusive read was seen.
- R9: Op code 5 (evict) from Modified or Owned copies `arr_data` into the record and raises `iss_wb`. Until the own writeback is ordered, other reads are served from the record. Another controller's exclusive read is also served, and afterwards the line stays lost. The own writeback ends in Invalid.
- R10: `perm` is 0 in not-present, Invalid and in the writeback waits that began from Modified or that lost the line; 1 in Shared and Owned; 2 in Modified; 3 (busy) in every other transient state.
- R11: In a transient state, load, fetch, store and evict are held (`proc_ready` low). Prefetches are accepted and dropped while a read or exclusive read is pending, and held while a writeback is pending. `proc_ready` is also low whenever `snp_valid` or `dat_valid` is high.
- R12: `dat_ready` is low exactly when `snp_valid` is high. Data that arrives in a state that expects none is consumed with no effect.
- R13: A store in Shared or Owned raises `iss_rdx`. If another controller's exclusive read is ordered first, Shared and Owned drop to the wait a miss uses (Owned sends its data), and the request then completes as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_valid | input | 1 | Processor request present |
| proc_ready | output | 1 | Processor request taken this cycle |
| proc_op | input | 3 | Op code: 0 load, 1 fetch, 2 store, 3 load-prefetch, 4 store-prefetch, 5 evict |
| snp_valid | input | 1 | Snooped ordered request present (always taken) |
| snp_type | input | 2 | 0 shared read, 1 fetch read, 2 exclusive read, 3 writeback |
| snp_id | input | ID_W | Requestor ID of the snoop |
| dat_valid | input | 1 | Data arrival present |
| dat_ready | output | 1 | Data arrival taken this cycle |
| dat_data | input | DATA_W | Arriving line data |
| arr_data | input | DATA_W | Current line contents from the data array |
| iss_rd | output | 1 | Issue shared read |
| iss_ird | output | 1 | Issue fetch read |
| iss_rdx | output | 1 | Issue exclusive read |
| iss_wb | output | 1 | Issue writeback |
| send_valid | output | 1 | Send data this cycle |
| send_dest | output | N_NODES | Destination bitmask of the send |
| send_data | output | DATA_W | Data being sent |
| fill_valid | output | 1 | Write line into the array |
| fill_data | output | DATA_W | Data to write |
| done_ld | output | 1 | Load or fetch completed |
| done_st | output | 1 | Store completed |
| perm | output | 2 | Access permission: 0 none, 1 read, 2 read-write, 3 busy |

## Verification
The bench builds the block with four nodes, `MY_ID` set to 2 and 16-bit data. A non-zero own ID checks that own-versus-other classification compares every ID bit. Three other IDs let the forward mask gather several readers, and an exclusive read after them, in one data wait. Scripted interleavings cover both orders of data and own request, upgrades that lose to another writer, prefetch-started misses and writebacks that lose the line. A long random phase then mixes own and other snoops, data and held processor requests against the reference model.

// File: rtl/mosi_line_pkg.sv
package mosi_line_pkg;

  typedef enum logic [4:0] {
    LS_NP, LS_I, LS_S, LS_O, LS_M,
    W_RD_BOTH, W_WR_BOTH, W_UP_BOTH, W_OWN_ORD,
    W_RD_ORD, W_WR_ORD, W_UP_ORD,
    WB_MOD, WB_OWN, WB_LOST,
    W_RD_DAT, W_RD_DAT_INV,
    W_WR_DAT, W_WR_DAT_SH, W_WR_DAT_INV, W_WR_DAT_SHINV,
    W_UP_DAT, W_UP_DAT_SH
  } lstate_t;

  typedef enum logic [2:0] {
    OP_LOAD = 3'd0, OP_FETCH = 3'd1, OP_STORE = 3'd2,
    OP_LOAD_PF = 3'd3, OP_STORE_PF = 3'd4, OP_EVICT = 3'd5
  } pop_t;

  typedef enum logic [1:0] {
    PM_NONE = 2'd0, PM_RO = 2'd1, PM_RW = 2'd2, PM_BUSY = 2'd3
  } perm_t;

endpackage

// File: rtl/mlc_snoop_dec.sv
module mlc_snoop_dec #(
  parameter int ID_W  = 2,
  parameter int MY_ID = 0
) (
  input  logic            valid,
  input  logic [1:0]      kind,
  input  logic [ID_W-1:0] id,
  output logic            own_rd,
  output logic            own_rx,
  output logic            own_wb,
  output logic            oth_rd,
  output logic            oth_rx
);
  logic mine;
  assign mine   = (id == ID_W'(MY_ID));
  assign own_rd = valid &&  mine && (kind == 2'd0 || kind == 2'd1);
  assign own_rx = valid &&  mine && (kind == 2'd2);
  assign own_wb = valid &&  mine && (kind == 2'd3);
  assign oth_rd = valid && !mine && (kind == 2'd0 || kind == 2'd1);
  assign oth_rx = valid && !mine && (kind == 2'd2);
endmodule

// File: rtl/mlc_record.sv
module mlc_record #(
  parameter int N_NODES = 4,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              alloc_pf,
  input  logic              free,
  input  logic              add_fwd,
  input  logic [ID_W-1:0]   add_id,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_data,
  output logic              act,
  output logic              pf,
  output logic [N_NODES-1:0] fwd,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      pf  <= 1'b0;
    end else if (free) begin
      act <= 1'b0;
      pf  <= 1'b0;
    end else if (alloc) begin
      act <= 1'b1;
      pf  <= alloc_pf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data <= '0;
    else if (cap_en) data <= cap_data;
  end

  for (genvar i = 0; i < N_NODES; i++) begin : g_fwd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               fwd[i] <= 1'b0;
      else if (free || alloc)                   fwd[i] <= 1'b0;
      else if (add_fwd && add_id == ID_W'(i))   fwd[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/mlc_perm.sv
module mlc_perm
  import mosi_line_pkg::*;
(
  input  lstate_t st,
  output perm_t   pm
);
  always_comb begin
    case (st)
      LS_NP, LS_I, WB_MOD, WB_LOST: pm = PM_NONE;
      LS_S, LS_O:                   pm = PM_RO;
      LS_M:                         pm = PM_RW;
      default:                      pm = PM_BUSY;
    endcase
  end
endmodule

// File: rtl/mosi_line_ctrl.sv
module mosi_line_ctrl
  import mosi_line_pkg::*;
#(
  parameter int N_NODES = 4,
  parameter int MY_ID   = 0,
  parameter int DATA_W  = 32,
  localparam int ID_W   = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               proc_valid,
  output logic               proc_ready,
  input  logic [2:0]         proc_op,
  input  logic               snp_valid,
  input  logic [1:0]         snp_type,
  input  logic [ID_W-1:0]    snp_id,
  input  logic               dat_valid,
  output logic               dat_ready,
  input  logic [DATA_W-1:0]  dat_data,
  input  logic [DATA_W-1:0]  arr_data,
  output logic               iss_rd,
  output logic               iss_ird,
  output logic               iss_rdx,
  output logic               iss_wb,
  output logic               send_valid,
  output logic [N_NODES-1:0] send_dest,
  output logic [DATA_W-1:0]  send_data,
  output logic               fill_valid,
  output logic [DATA_W-1:0]  fill_data,
  output logic               done_ld,
  output logic               done_st,
  output logic [1:0]         perm
);
  lstate_t st_q, st_d;
  pop_t    op;
  perm_t   pm;
  logic own_rd, own_rx, own_wb, oth_rd, oth_rx;
  logic rec_act, rec_pf;
  logic [N_NODES-1:0] rec_fwd;
  logic [DATA_W-1:0]  rec_data;
  logic alloc, alloc_pf, free, add_fwd, cap_en, cap_arr;
  logic hit_ld, hit_st, to_req, to_fwd, from_rec, fill_rec;
  logic stable, wb_wait, is_pf, is_rd, is_wr, p_go, d_go;

  assign op = pop_t'(proc_op);

  mlc_snoop_dec #(.ID_W(ID_W), .MY_ID(MY_ID)) u_dec (
    .valid(snp_valid), .kind(snp_type), .id(snp_id),
    .own_rd(own_rd), .own_rx(own_rx), .own_wb(own_wb),
    .oth_rd(oth_rd), .oth_rx(oth_rx));

  mlc_record #(.N_NODES(N_NODES), .DATA_W(DATA_W), .ID_W(ID_W)) u_rec (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .alloc_pf(alloc_pf), .free(free),
    .add_fwd(add_fwd), .add_id(snp_id), .cap_en(cap_en),
    .cap_data(cap_arr ? arr_data : dat_data),
    .act(rec_act), .pf(rec_pf), .fwd(rec_fwd), .data(rec_data));

  mlc_perm u_perm (.st(st_q), .pm(pm));
  assign perm = pm;

  assign stable  = (st_q == LS_NP) || (st_q == LS_I) || (st_q == LS_S) ||
                   (st_q == LS_O)  || (st_q == LS_M);
  assign wb_wait = (st_q == WB_MOD) || (st_q == WB_OWN) || (st_q == WB_LOST);
  assign is_pf   = (op == OP_LOAD_PF) || (op == OP_STORE_PF);
  assign is_rd   = (op == OP_LOAD) || (op == OP_FETCH) || (op == OP_LOAD_PF);
  assign is_wr   = (op == OP_STORE) || (op == OP_STORE_PF);

  assign dat_ready  = !snp_valid;
  assign proc_ready = !snp_valid && !dat_valid && (stable || (!wb_wait && is_pf));
  assign d_go       = dat_valid && !snp_valid;
  assign p_go       = proc_valid && proc_ready;

  always_comb begin
    st_d = st_q;
    {iss_rd, iss_ird, iss_rdx, iss_wb} = '0;
    {alloc, alloc_pf, free, add_fwd, cap_en, cap_arr} = '0;
    {hit_ld, hit_st, to_req, to_fwd, from_rec, fill_valid, fill_rec} = '0;
    if (snp_valid) begin
      case (st_q)
        LS_S: if (oth_rx) st_d = LS_I;
        LS_O: begin
          to_req = oth_rd || oth_rx;
          if (oth_rx) st_d = LS_I;
        end
        LS_M: begin
          to_req = oth_rd || oth_rx;
          if (oth_rd) st_d = LS_O;
          if (oth_rx) st_d = LS_I;
        end
        W_RD_BOTH: if (own_rd) st_d = W_RD_DAT;
        W_WR_BOTH: if (own_rx) st_d = W_WR_DAT;
        W_UP_BOTH: begin
          if (own_rx) st_d = W_UP_DAT;
          if (oth_rx) st_d = W_WR_BOTH;
        end
        W_OWN_ORD: begin
          to_req = oth_rd || oth_rx;
          if (oth_rx) st_d = W_WR_BOTH;
          if (own_rx) begin st_d = LS_M; hit_st = 1'b1; free = 1'b1; end
        end
        W_RD_ORD: if (own_rd) begin
          st_d = LS_S; fill_valid = 1'b1; fill_rec = 1'b1; hit_ld = 1'b1; free = 1'b1;
        end
        W_WR_ORD, W_UP_ORD: begin
          if (own_rx) begin
            st_d = LS_M; fill_valid = 1'b1; fill_rec = 1'b1; hit_st = 1'b1; free = 1'b1;
          end
          if (oth_rx && st_q == W_UP_ORD) st_d = W_WR_ORD;
        end
        WB_MOD, WB_OWN: begin
          to_req = oth_rd || oth_rx;
          from_rec = 1'b1;
          if (oth_rx) st_d = WB_LOST;
          if (own_wb) begin st_d = LS_I; free = 1'b1; end
        end
        WB_LOST: if (own_wb) begin st_d = LS_I; free = 1'b1; end
        W_RD_DAT: if (oth_rx) st_d = W_RD_DAT_INV;
        W_WR_DAT, W_UP_DAT, W_WR_DAT_SH, W_UP_DAT_SH: begin
          add_fwd = oth_rd || oth_rx;
          if (oth_rd && st_q == W_WR_DAT) st_d = W_WR_DAT_SH;
          if (oth_rd && st_q == W_UP_DAT) st_d = W_UP_DAT_SH;
          if (oth_rx) st_d = (st_q == W_WR_DAT || st_q == W_UP_DAT) ? W_WR_DAT_INV
                                                                    : W_WR_DAT_SHINV;
        end
        default: ;
      endcase
    end else if (d_go) begin
      case (st_q)
        W_RD_BOTH: begin cap_en = 1'b1; st_d = W_RD_ORD; end
        W_WR_BOTH, W_OWN_ORD: begin cap_en = 1'b1; st_d = W_WR_ORD; end
        W_UP_BOTH: begin cap_en = 1'b1; st_d = W_UP_ORD; end
        W_RD_DAT, W_RD_DAT_INV: begin
          fill_valid = 1'b1; hit_ld = 1'b1; free = 1'b1;
          st_d = (st_q == W_RD_DAT) ? LS_S : LS_I;
        end
        W_WR_DAT, W_UP_DAT: begin
          fill_valid = 1'b1; hit_st = 1'b1; free = 1'b1; st_d = LS_M;
        end
        W_WR_DAT_SH, W_UP_DAT_SH, W_WR_DAT_INV, W_WR_DAT_SHINV: begin
          fill_valid = 1'b1; hit_st = 1'b1; free = 1'b1; to_fwd = 1'b1;
          st_d = (st_q == W_WR_DAT_SH || st_q == W_UP_DAT_SH) ? LS_O : LS_I;
        end
        default: ;
      endcase
    end else if (p_go) begin
      case (st_q)
        LS_NP, LS_I: begin
          if (is_rd || is_wr) begin alloc = 1'b1; alloc_pf = is_pf; end
          if (is_rd) begin
            st_d = W_RD_BOTH;
            iss_ird = (op == OP_FETCH);
            iss_rd  = (op != OP_FETCH);
          end
          if (is_wr) begin st_d = W_WR_BOTH; iss_rdx = 1'b1; end
          if (op == OP_EVICT) st_d = LS_NP;
        end
        LS_S, LS_O, LS_M: begin
          hit_ld = (op == OP_LOAD) || (op == OP_FETCH);
          if (is_wr && st_q != LS_M) begin
            alloc = 1'b1; alloc_pf = is_pf; iss_rdx = 1'b1;
            st_d = (st_q == LS_O) ? W_OWN_ORD : (is_pf ? W_WR_BOTH : W_UP_BOTH);
          end
          if (op == OP_STORE && st_q == LS_M) hit_st = 1'b1;
          if (op == OP_EVICT) begin
            if (st_q == LS_S) st_d = LS_I;
            else begin
              alloc = 1'b1; cap_en = 1'b1; cap_arr = 1'b1; iss_wb = 1'b1;
              st_d = (st_q == LS_M) ? WB_MOD : WB_OWN;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LS_NP;
    else        st_q <= st_d;
  end

  assign done_ld    = hit_ld && !(rec_act && rec_pf);
  assign done_st    = hit_st && !(rec_act && rec_pf);
  assign send_valid = to_req || to_fwd;
  assign send_dest  = to_fwd ? rec_fwd : (to_req ? N_NODES'(1) << snp_id : '0);
  assign send_data  = to_fwd ? dat_data : (from_rec ? rec_data : arr_data);
  assign fill_data  = fill_rec ? rec_data : dat_data;
endmodule

// File: rtl/mlc_checker.sv
module mlc_checker #(
  parameter int N_NODES = 4,
  parameter int MY_ID   = 0,
  parameter int ID_W    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               proc_valid,
  input logic               proc_ready,
  input logic [2:0]         proc_op,
  input logic               snp_valid,
  input logic [1:0]         snp_type,
  input logic [ID_W-1:0]    snp_id,
  input logic               dat_ready,
  input logic               iss_rd,
  input logic               iss_ird,
  input logic               iss_rdx,
  input logic               iss_wb,
  input logic               send_valid,
  input logic [N_NODES-1:0] send_dest,
  input logic [1:0]         perm
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> perm == 2'd0);

  p_one_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({iss_rd, iss_ird, iss_rdx, iss_wb}));

  p_other_wb_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_type == 2'd3 && snp_id != ID_W'(MY_ID)) |=> $stable(perm));

  p_send_has_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    send_valid |-> send_dest != '0);

  p_wb_drops_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iss_wb |=> (perm == 2'd0 || perm == 2'd3));

  p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (perm == 2'd3 && proc_valid && proc_op != 3'd3 && proc_op != 3'd4) |-> !proc_ready);

  p_snoop_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!dat_ready && !proc_ready));
endmodule

bind mosi_line_ctrl mlc_checker #(.N_NODES(N_NODES), .MY_ID(MY_ID), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .proc_valid(proc_valid), .proc_ready(proc_ready),
  .proc_op(proc_op), .snp_valid(snp_valid), .snp_type(snp_type), .snp_id(snp_id),
  .dat_ready(dat_ready), .iss_rd(iss_rd), .iss_ird(iss_ird), .iss_rdx(iss_rdx),
  .iss_wb(iss_wb), .send_valid(send_valid), .send_dest(send_dest), .perm(perm));

// File: tb/sim_mosi_line_ctrl.sv
module sim_mosi_line_ctrl;
  localparam int N = 4, ME = 2, DW = 16, IW = 2;
  // model states
  localparam int mNP=0, mI=1, mS=2, mO=3, mM=4, mRdAD=5, mWrAD=6, mUpAD=7, mOwA=8,
                 mRdA=9, mWrA=10, mUpA=11, mWbM=12, mWbO=13, mWbX=14, mRdD=15, mRdDI=16,
                 mWrD=17, mWrDS=18, mWrDI=19, mWrDSI=20, mUpD=21, mUpDS=22;

  logic clk = 1'b0, rst_n = 1'b0;
  logic proc_valid = 0, snp_valid = 0, dat_valid = 0;
  logic [2:0] proc_op = 0;
  logic [1:0] snp_type = 0;
  logic [IW-1:0] snp_id = 0;
  logic [DW-1:0] dat_data = 0, arr_data = 0;
  logic proc_ready, dat_ready, iss_rd, iss_ird, iss_rdx, iss_wb;
  logic send_valid, fill_valid, done_ld, done_st;
  logic [N-1:0] send_dest;
  logic [DW-1:0] send_data, fill_data;
  logic [1:0] perm;

  int nchk = 0, nerr = 0, cyc = 0, n_ld = 0, n_st = 0;
  int m_st = mNP;
  bit m_act = 0, m_pf = 0, finished = 0;
  logic [N-1:0] m_fwd = 0;
  logic [DW-1:0] m_dat = 0;

  always #2 clk = ~clk;

  mosi_line_ctrl #(.N_NODES(N), .MY_ID(ME), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .proc_valid(proc_valid), .proc_ready(proc_ready),
    .proc_op(proc_op), .snp_valid(snp_valid), .snp_type(snp_type), .snp_id(snp_id),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data), .arr_data(arr_data),
    .iss_rd(iss_rd), .iss_ird(iss_ird), .iss_rdx(iss_rdx), .iss_wb(iss_wb),
    .send_valid(send_valid), .send_dest(send_dest), .send_data(send_data),
    .fill_valid(fill_valid), .fill_data(fill_data), .done_ld(done_ld), .done_st(done_st),
    .perm(perm));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int perm_of(input int s);
    if (s == mNP || s == mI || s == mWbM || s == mWbX) return 0;
    if (s == mS || s == mO) return 1;
    if (s == mM) return 2;
    return 3;
  endfunction

  // reference model, evaluated between edges on the inputs driven after the last edge
  always @(negedge clk) begin
    int nx; bit nact, npf, hl, hs, sv, fv, stab, wbw, pf, rd, wr, own;
    logic [3:0] iss; logic [N-1:0] nfwd, sd; logic [DW-1:0] ndat, sdat, fdat;
    logic e_ready;
    cyc++;
    if (u0.rst_n === 1'b0) begin
      m_st = mNP; m_act = 0; m_pf = 0; m_fwd = 0; m_dat = 0;
    end else begin
      nx = m_st; nact = m_act; npf = m_pf; nfwd = m_fwd; ndat = m_dat;
      hl = 0; hs = 0; sv = 0; fv = 0; iss = 0; sd = 0; sdat = 0; fdat = 0;
      stab = (m_st <= mM);
      wbw  = (m_st == mWbM || m_st == mWbO || m_st == mWbX);
      pf   = (proc_op == 3 || proc_op == 4);
      rd   = (snp_type <= 1);
      own  = (snp_id == IW'(ME));
      e_ready = !snp_valid && !dat_valid && (stab || (!wbw && pf));
      if (snp_valid && own) begin
        if (rd && m_st == mRdAD) nx = mRdD;
        if (rd && m_st == mRdA) begin nx = mS; fv = 1; fdat = m_dat; hl = 1; nact = 0; end
        if (snp_type == 2) begin
          if (m_st == mWrAD) nx = mWrD;
          if (m_st == mUpAD) nx = mUpD;
          if (m_st == mOwA) begin nx = mM; hs = 1; nact = 0; end
          if (m_st == mWrA || m_st == mUpA) begin nx = mM; fv = 1; fdat = m_dat; hs = 1; nact = 0; end
        end
        if (snp_type == 3 && wbw) begin nx = mI; nact = 0; end
      end else if (snp_valid && snp_type != 3) begin
        wr = (snp_type == 2);
        case (m_st)
          mS: if (wr) nx = mI;
          mO, mM, mOwA: begin
            sv = 1; sd = N'(1) << snp_id; sdat = arr_data;
            if (wr) nx = (m_st == mOwA) ? mWrAD : mI;
            else if (m_st == mM) nx = mO;
          end
          mWbM, mWbO: begin sv = 1; sd = N'(1) << snp_id; sdat = m_dat; if (wr) nx = mWbX; end
          mUpAD: if (wr) nx = mWrAD;
          mUpA:  if (wr) nx = mWrA;
          mRdD:  if (wr) nx = mRdDI;
          mWrD, mUpD, mWrDS, mUpDS: begin
            nfwd[snp_id] = 1'b1;
            if (wr) nx = (m_st == mWrD || m_st == mUpD) ? mWrDI : mWrDSI;
            else if (m_st == mWrD) nx = mWrDS;
            else if (m_st == mUpD) nx = mUpDS;
          end
          default: ;
        endcase
      end else if (!snp_valid && dat_valid) begin
        case (m_st)
          mRdAD: begin ndat = dat_data; nx = mRdA; end
          mWrAD, mOwA: begin ndat = dat_data; nx = mWrA; end
          mUpAD: begin ndat = dat_data; nx = mUpA; end
          mRdD, mRdDI: begin fv = 1; fdat = dat_data; hl = 1; nact = 0; nx = (m_st == mRdD) ? mS : mI; end
          mWrD, mUpD: begin fv = 1; fdat = dat_data; hs = 1; nact = 0; nx = mM; end
          mWrDS, mUpDS, mWrDI, mWrDSI: begin
            fv = 1; fdat = dat_data; hs = 1; nact = 0; sv = 1; sd = m_fwd; sdat = dat_data;
            nx = (m_st == mWrDS || m_st == mUpDS) ? mO : mI;
          end
          default: ;
        endcase
      end else if (proc_valid && e_ready && stab) begin
        if (m_st <= mI) begin
          if (proc_op == 0 || proc_op == 3) begin iss = 4'b1000; nx = mRdAD; end
          if (proc_op == 1) begin iss = 4'b0100; nx = mRdAD; end
          if (proc_op == 2 || proc_op == 4) begin iss = 4'b0010; nx = mWrAD; end
          if (proc_op <= 4) begin nact = 1; npf = pf; nfwd = 0; end
          if (proc_op == 5) nx = mNP;
        end else begin
          if (proc_op <= 1) hl = 1;
          if (proc_op == 2 && m_st == mM) hs = 1;
          if ((proc_op == 2 || proc_op == 4) && m_st != mM) begin
            iss = 4'b0010; nact = 1; npf = pf; nfwd = 0;
            nx = (m_st == mO) ? mOwA : (proc_op == 4 ? mWrAD : mUpAD);
          end
          if (proc_op == 5) begin
            if (m_st == mS) nx = mI;
            else begin iss = 4'b0001; nact = 1; npf = 0; nfwd = 0; ndat = arr_data;
                       nx = (m_st == mM) ? mWbM : mWbO; end
          end
        end
      end
      if (!nact) begin npf = 0; nfwd = 0; end
      chk("R10 perm", perm, perm_of(m_st));
      chk("R11 proc_ready", proc_ready, e_ready);
      chk("R12 dat_ready", dat_ready, !snp_valid);
      chk("R3 request strobes", {iss_rd, iss_ird, iss_rdx, iss_wb}, iss);
      chk("R4 done_ld", done_ld, hl && !(m_act && m_pf));
      chk("R5 done_st", done_st, hs && !(m_act && m_pf));
      chk("R6 send_valid", send_valid, sv);
      if (sv) begin
        chk("R8 send_dest", send_dest, sd);
        chk("R9 send_data", send_data, sdat);
      end
      chk("R7 fill_valid", fill_valid, fv);
      if (fv) chk("R7 fill_data", fill_data, fdat);
      m_st = nx; m_act = nact; m_pf = npf; m_fwd = nfwd; m_dat = ndat;
      n_ld += int'(done_ld); n_st += int'(done_st);
    end
  end

  task automatic step();
    @(posedge clk); #1;
    proc_valid = 0; snp_valid = 0; dat_valid = 0;
  endtask
  task automatic req(input logic [2:0] op);
    proc_valid = 1; proc_op = op; step();
  endtask
  task automatic snp(input logic [1:0] t, input int id);
    snp_valid = 1; snp_type = t; snp_id = IW'(id); step();
  endtask
  task automatic dat(input logic [DW-1:0] d);
    dat_valid = 1; dat_data = d; step();
  endtask
  task automatic see_perm(input string tag, input int exp);
    @(negedge clk); chk(tag, perm, exp); @(posedge clk); #1;
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin : main
    int ld0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    @(negedge clk);
    chk("R1 perm at reset", perm, 0);
    chk("R1 proc_ready at reset", proc_ready, 1);
    chk("R1 no send at reset", send_valid, 0);
    rst_n = 1; @(posedge clk); #1;
    see_perm("R1 perm after reset", 0);
    // R3: load miss, ordered before data
    arr_data = 16'h1111;
    req(0); see_perm("R3 busy after miss", 3);
    snp(0, 1);                 // other read, ignored
    snp(0, ME); dat(16'hA5A5); see_perm("R3 shared after fill", 1);
    req(1);                    // R4 fetch hit
    // R13: upgrade from shared loses to other writer
    req(2); snp(2, 0); see_perm("R13 upgrade demoted", 3);
    snp(2, ME); dat(16'h0B0B); see_perm("R13 modified", 2);
    // R2: other writeback ignored, own id needed
    snp(3, 1); see_perm("R2 other writeback ignored", 2);
    req(2); req(3);
    // R6: owner answers readers and writer
    snp(1, 3); see_perm("R6 owned after other read", 1);
    snp(2, 1); see_perm("R6 invalid after other write", 0);
    // R8: forward set gathers readers then writer
    req(2); snp(2, ME); snp(0, 1); snp(1, 3); req(0); snp(2, 0); snp(0, 3);
    dat(16'hC0DE); see_perm("R8 invalid after forwarding", 0);
    req(4); snp(2, ME); snp(0, 0); dat(16'h7777); see_perm("R8 owned after forward", 1);
    // R7: data before own ordering
    snp(2, 3); req(0); dat(16'h4242); see_perm("R7 busy with buffered data", 3);
    snp(0, ME); see_perm("R7 shared after own read", 1);
    // R5: prefetch miss completes silently
    snp(2, 1); ld0 = n_ld;
    req(3); snp(0, ME); dat(16'h9999);
    chk("R5 no completion for prefetch", n_ld, ld0);
    see_perm("R5 shared after prefetch", 1);
    // R9: eviction from modified, lost to writer
    req(2); snp(2, ME); dat(16'h5151); see_perm("R9 modified", 2);
    arr_data = 16'hE1E1; req(5); see_perm("R9 writeback wait", 0);
    req(0); snp(0, 1); snp(2, 3); snp(2, ME);
    snp(3, ME); see_perm("R9 invalid after own writeback", 0);
    req(5); see_perm("R1 evict from invalid", 0);
    // R11/R12: contention and random interleavings
    for (int i = 0; i < 6000; i++) begin
      arr_data   = DW'($urandom);
      proc_valid = ($urandom % 2) == 0;
      proc_op    = 3'($urandom % 6);
      snp_valid  = ($urandom % 10) < 3;
      snp_type   = 2'($urandom);
      snp_id     = (($urandom % 5) < 2) ? IW'(ME) : IW'($urandom);
      dat_valid  = ($urandom % 5) == 0;
      dat_data   = DW'($urandom);
      @(posedge clk); #1;
    end
    proc_valid = 0; snp_valid = 0; dat_valid = 0;
    repeat (2) @(posedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule